// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an on-chip clocked request port and an external asynchronous static RAM. The RAM has a word address, a 16-bit data bus split into two byte lanes, and active-low select, write, output and per-lane byte strobes. The controller takes one read or one write at a time. It turns that request into a strobe sequence in which every analog minimum becomes a whole number of clock cycles. When the access is complete it returns a one-cycle completion pulse, and for a read it returns the captured word with that pulse.

Each timing minimum is a parameter in clock cycles, rounded up from the clock period. With a 10 ns clock the defaults are: a 5-cycle access, a 4-cycle write pulse, a 4-cycle address-to-write-end setup, a 3-cycle data setup, a 5-cycle read access and a 2-cycle bus turnaround. The controller registers every pin it drives, so the active-low strobes cannot glitch. The data bus is split into an output word, an input word and a per-lane drive enable, which the pad ring joins into the bidirectional pins.

Top module: `sram_ctrl`

## Requirements
- R1: While idle, and throughout reset, `mem_ce_n`, `mem_we_n`, `mem_oe_n` and both bits of `mem_be_n` are 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the completion cycle, and `req_valid` has no effect while `req_ready` is 0.
- R3: A write has three phases. First comes one setup cycle with `mem_ce_n`=0, the address, byte strobes and data driven and `mem_we_n`=1. Next `mem_we_n`=0 for WP cycles, where WP = max(write pulse, data setup - 1, address setup - 1), which is 4 by default. Last come HD cycles with `mem_we_n`=1 and chip select, address and data still held, where HD = max(1, access - 1 - WP), which is 1 by default.
- R4: A read asserts `mem_ce_n`, `mem_oe_n` and the selected byte strobes low together for RD cycles, where RD = max(2, read access, access), which is 5 by default. `mem_dq_i` is captured on the edge that ends the last of those cycles, and then all strobes return high.
- R5: After a read releases `mem_oe_n`, the controller waits TA cycles before completion, where TA = max(1, turnaround) and is 2 by default. No lane drive enable rises within TA cycles of `mem_oe_n` going high.
- R6: Mask bit 0 selects data bits 7:0 through `mem_be_n[0]`, and mask bit 1 selects bits 15:8 through `mem_be_n[1]`. A strobe is low exactly when its mask bit is 1. A write drives only selected lanes, so unselected lanes keep their stored value. A read returns 0 in unselected lanes.
- R7: `rsp_done` is a one-cycle pulse in the first idle cycle after an access. For a read, `rsp_rdata` carries the captured word in that cycle.
- R8: While `mem_we_n` is low, `mem_ce_n` is low, and the address, byte strobes, chip select and write data do not change.
- R9: `mem_oe_n` and `mem_we_n` are never low together, and no lane is driven while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane select, bit 0 = low byte |
| rsp_done | output | 1 | Access complete pulse |
| rsp_rdata | output | 16 | Read data, valid with `rsp_done` |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_be_n | output | 2 | RAM byte strobes, active low |
| mem_dq_o | output | 16 | Data toward RAM |
| mem_dq_oe | output | 2 | Per-lane drive enable for `mem_dq_o` |
| mem_dq_i | input | 16 | Data from RAM |

## Verification
The hardest case to reach is a write that is presented while a read is still in progress. Only then does the turnaround gap lie between `mem_oe_n` releasing and the lane drivers turning on. The stimulus therefore holds a write request on the port from the cycle after a read is taken. The write is taken in the very cycle the read completes. A second hard case is reading too early. The bench's RAM model returns valid data only after the strobes have been low for the full read access, so capturing one edge early gives a corrupted word. A third case is the partial-lane write, which is read back through the other lane to show the untouched byte survived.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RWAIT,
        ST_WPULSE,
        ST_HOLD,
        ST_TURN
    } sramc_state_e;

    function automatic int cmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   mask,
    input  logic [LANES*8-1:0] dq_i,
    output logic [LANES*8-1:0] rd_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rd_o[l*8 +: 8] = mask[l] ? dq_i[l*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int CYC_RC = 5,
    parameter int CYC_RD = 5,
    parameter int CYC_WP = 4,
    parameter int CYC_AW = 4,
    parameter int CYC_DS = 3,
    parameter int CYC_TA = 2,
    parameter int CNT_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  rsp_done,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_o,
    output logic [DATA_W/8-1:0]   mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_i
);
    localparam int LANES  = DATA_W / 8;
    localparam int WP_LEN = cmax(CYC_WP, cmax(CYC_DS - 1, CYC_AW - 1));
    localparam int HD_LEN = cmax(1, CYC_RC - 1 - WP_LEN);
    localparam int RD_LEN = cmax(2, cmax(CYC_RD, CYC_RC));
    localparam int TA_LEN = cmax(1, CYC_TA);

    typedef struct packed {
        sramc_state_e        state;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [LANES-1:0]    mask;
        logic                ce_n;
        logic                we_n;
        logic                oe_n;
        logic [LANES-1:0]    be_n;
        logic [LANES-1:0]    dq_oe;
        logic                done;
        logic [DATA_W-1:0]   rdata;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_exp;
    logic [DATA_W-1:0] rd_masked;

    sramc_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    sramc_lanes #(.LANES(LANES)) u_lanes (
        .mask (ctl_q.mask),
        .dq_i (mem_dq_i),
        .rd_o (rd_masked)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state = ST_SETUP;
                    ctl_d.wr    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.mask  = req_mask;
                    ctl_d.ce_n  = 1'b0;
                    ctl_d.be_n  = ~req_mask;
                    if (req_write) ctl_d.dq_oe = req_mask;
                    else           ctl_d.oe_n  = 1'b0;
                end
            end
            ST_SETUP: begin
                tmr_load = 1'b1;
                if (ctl_q.wr) begin
                    ctl_d.state = ST_WPULSE;
                    ctl_d.we_n  = 1'b0;
                    tmr_val     = CNT_W'(WP_LEN - 1);
                end else begin
                    ctl_d.state = ST_RWAIT;
                    tmr_val     = CNT_W'(RD_LEN - 2);
                end
            end
            ST_WPULSE: begin
                if (tmr_exp) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.we_n  = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(HD_LEN - 1);
                end
            end
            ST_HOLD: begin
                if (tmr_exp) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.be_n  = '1;
                    ctl_d.dq_oe = '0;
                    ctl_d.done  = 1'b1;
                end
            end
            ST_RWAIT: begin
                if (tmr_exp) begin
                    ctl_d.state = ST_TURN;
                    ctl_d.rdata = rd_masked;
                    ctl_d.ce_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.be_n  = '1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(TA_LEN - 1);
                end
            end
            ST_TURN: begin
                if (tmr_exp) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
            ctl_q.oe_n  <= 1'b1;
            ctl_q.be_n  <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign rsp_done  = ctl_q.done;
    assign rsp_rdata = ctl_q.rdata;
    assign mem_addr  = ctl_q.addr;
    assign mem_ce_n  = ctl_q.ce_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_be_n  = ctl_q.be_n;
    assign mem_dq_o  = ctl_q.wdata;
    assign mem_dq_oe = ctl_q.dq_oe;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int TA_LEN = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic [LANES-1:0]  mem_dq_oe
);
    logic [7:0] since_oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   since_oe_q <= 8'(TA_LEN + 1);
        else if (!mem_oe_n)           since_oe_q <= '0;
        else if (since_oe_q < 8'(TA_LEN + 1)) since_oe_q <= since_oe_q + 1'b1;
    end

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && (&mem_be_n) && (mem_dq_oe == '0)));

    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r5_turnaround_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dq_oe != '0) |-> (since_oe_q >= 8'(TA_LEN)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r8_we_inside_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    a_r8_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |->
            ($stable(mem_addr) && $stable(mem_be_n) && $stable(mem_ce_n) && $stable(mem_dq_o)));

    a_r9_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && (mem_dq_oe == '0)));
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .TA_LEN (TA_LEN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;
    localparam int WP = 4;
    localparam int HD = 1;
    localparam int RD = 5;
    localparam int TA = 2;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0, req_write = 0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n, mem_dq_oe;
    logic [15:0] mem_dq_o;
    logic [15:0] mem_dq_i = 16'hA5A5;

    int checks = 0, errors = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    typedef struct {
        logic ce_n, we_n, oe_n, ready, done, chk_addr, chk_rd;
        logic [1:0]  be_n, dq_oe;
        logic [17:0] addr;
        logic [15:0] dq_o, rdata;
    } vec_t;

    vec_t exp_q[$];
    logic [15:0] shadow [logic [17:0]];
    logic [15:0] ram    [logic [17:0]];
    int act_cnt = 0;

    function automatic vec_t idle_vec();
        vec_t v;
        v.ce_n = 1; v.we_n = 1; v.oe_n = 1; v.ready = 1; v.done = 0;
        v.chk_addr = 0; v.chk_rd = 0; v.be_n = 2'b11; v.dq_oe = 2'b00;
        v.addr = '0; v.dq_o = '0; v.rdata = '0;
        return v;
    endfunction

    // reference model: expected pin sequence per accepted request
    always @(posedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            vec_t v;
            logic [15:0] old;
            old = shadow.exists(req_addr) ? shadow[req_addr] : 16'h0000;
            v = idle_vec();
            v.ready = 0; v.chk_addr = 1; v.addr = req_addr; v.dq_o = req_wdata;
            v.ce_n = 0; v.be_n = ~req_mask;
            if (req_write) begin
                v.dq_oe = req_mask;
                exp_q.push_back(v);
                v.we_n = 0;
                for (int i = 0; i < WP; i++) exp_q.push_back(v);
                v.we_n = 1;
                for (int i = 0; i < HD; i++) exp_q.push_back(v);
                v = idle_vec(); v.done = 1;
                exp_q.push_back(v);
                for (int l = 0; l < 2; l++)
                    if (req_mask[l]) old[l*8 +: 8] = req_wdata[l*8 +: 8];
                shadow[req_addr] = old;
            end else begin
                v.oe_n = 0;
                for (int i = 0; i < RD; i++) exp_q.push_back(v);
                v = idle_vec(); v.ready = 0;
                for (int i = 0; i < TA; i++) exp_q.push_back(v);
                v = idle_vec(); v.done = 1; v.chk_rd = 1;
                for (int l = 0; l < 2; l++)
                    v.rdata[l*8 +: 8] = req_mask[l] ? old[l*8 +: 8] : 8'h00;
                exp_q.push_back(v);
            end
        end
    end

    // RAM model and per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && mem_dq_oe == 0,
                "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 32'h7C);
        end else begin
            vec_t e;
            string t;
            logic [15:0] w, dq;
            e = (exp_q.size() != 0) ? exp_q.pop_front() : idle_vec();
            t = (e.ready && !e.done) ? "R1" : "";
            chk(mem_ce_n == e.ce_n, {t, " R3 ce_n"}, mem_ce_n, e.ce_n);
            chk(mem_we_n == e.we_n, {t, " R3 we_n"}, mem_we_n, e.we_n);
            chk(mem_oe_n == e.oe_n, {t, " R4 oe_n"}, mem_oe_n, e.oe_n);
            chk(mem_be_n == e.be_n, {t, " R6 be_n"}, mem_be_n, e.be_n);
            chk(mem_dq_oe == e.dq_oe, {t, " R5 dq_oe"}, mem_dq_oe, e.dq_oe);
            chk(req_ready == e.ready, {t, " R2 ready"}, req_ready, e.ready);
            chk(rsp_done == e.done, {t, " R7 done"}, rsp_done, e.done);
            if (e.chk_addr) chk(mem_addr == e.addr, "R3 addr", mem_addr, e.addr);
            for (int l = 0; l < 2; l++)
                if (e.dq_oe[l]) chk(mem_dq_o[l*8 +: 8] == e.dq_o[l*8 +: 8], "R6 dq_o lane",
                                    mem_dq_o[l*8 +: 8], e.dq_o[l*8 +: 8]);
            if (e.chk_rd) chk(rsp_rdata == e.rdata, "R4 R7 rdata", rsp_rdata, e.rdata);

            w = ram.exists(mem_addr) ? ram[mem_addr] : 16'h0000;
            if (!mem_ce_n && !mem_we_n) begin
                for (int l = 0; l < 2; l++)
                    if (!mem_be_n[l] && mem_dq_oe[l]) w[l*8 +: 8] = mem_dq_o[l*8 +: 8];
                ram[mem_addr] = w;
            end
            act_cnt = (!mem_ce_n && !mem_oe_n) ? act_cnt + 1 : 0;
            dq = 16'hA5A5;
            for (int l = 0; l < 2; l++)
                if (act_cnt >= RD && !mem_be_n[l]) dq[l*8 +: 8] = w[l*8 +: 8];
            mem_dq_i <= dq;
        end
    end

    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        do @(posedge clk); while (!req_ready);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!rsp_done && n < 50) begin @(negedge clk); n++; end
        chk(rsp_done, "R7 completion seen", rsp_done, 1);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog act=%0d exp=%0d", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R3 full write then R4 full read
        issue(1, 18'h12345, 16'hBEEF, 2'b11); wait_done();
        issue(0, 18'h12345, 16'h0000, 2'b11); wait_done();
        // R6 lower-lane write keeps upper byte
        issue(1, 18'h12345, 16'h7755, 2'b01); wait_done();
        issue(0, 18'h12345, 16'h0000, 2'b11); wait_done();
        // R6 upper-lane write, lower-only read returns zero upper
        issue(1, 18'h12345, 16'h3300, 2'b10); wait_done();
        issue(0, 18'h12345, 16'h0000, 2'b01); wait_done();
        issue(0, 18'h12345, 16'h0000, 2'b10); wait_done();
        // R6 no-lane write changes nothing
        issue(1, 18'h12345, 16'hFFFF, 2'b00); wait_done();
        issue(0, 18'h12345, 16'h0000, 2'b11); wait_done();
        // address extremes
        issue(1, 18'h3FFFF, 16'h1234, 2'b11); wait_done();
        issue(1, 18'h00000, 16'hCAFE, 2'b11); wait_done();
        issue(0, 18'h3FFFF, 16'h0000, 2'b11); wait_done();
        issue(0, 18'h00000, 16'h0000, 2'b11); wait_done();
        // R2 valid pulsed while busy is ignored
        issue(0, 18'h3FFFF, 16'h0000, 2'b11);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 18'h00000; req_wdata = 16'h0BAD; req_mask = 2'b11;
        repeat (3) @(negedge clk);
        req_valid = 0;
        wait_done();
        issue(0, 18'h00000, 16'h0000, 2'b11); wait_done();
        // R5 write queued behind a read, taken in the completion cycle
        issue(0, 18'h12345, 16'h0000, 2'b11);
        issue(1, 18'h12345, 16'h4242, 2'b11); wait_done();
        issue(0, 18'h12345, 16'h0000, 2'b11); wait_done();
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R7 model drained", exp_q.size(), 0);
        finish_run();
    end
endmodule